// File: doc/BRIEF.md
# Compare-Match Timer Core

This block is a 16-bit event counter with a compare register, meant to sit behind a simple word-wide register port inside a larger chip. It runs in one of two modes. In time mode it counts strobes that a separate prescaler stage delivers on `count_en`. In pulse mode it counts active edges of one of four external pulse inputs, and the polarity setting chooses whether rising or falling edges count. When the counter holds the compare value and is then stepped, a sticky match flag sets and a trigger output rises. The match step either rewinds the counter to zero or lets it run on until it wraps past its top value.

Software sets the mode, input, polarity and prescaler fields while the timer is stopped, then sets the run bit. The match flag is cleared by writing a one to it. Clearing the run bit resets the counter, the flag and the trigger in one step. The prescaler settings are kept here and driven out to the prescaler stage unchanged.

Top module: `cmt_core`

## Requirements
- R1: After reset, every register reads zero and `irq` and `trig` are low.
- R2: The control word (byte offset 0x0) holds run at bit 0, mode at bit 1 (0 time, 1 pulse), free-run at bit 2, polarity at bit 3, input select at bits 5:4, interrupt enable at bit 6 and the match flag at bit 7. Bits 31:8 read zero.
- R3: In time mode with run set, the counter (offset 0xC) goes up by one on each cycle where `count_en` is high, and holds on other cycles.
- R4: In pulse mode, `count_en` is ignored. The counter steps once per rising edge of the selected input when polarity is 0, and once per falling edge when polarity is 1. Edges on the inputs that are not selected are ignored.
- R5: The match flag sets on a step taken while the counter equals the compare value. Writing 1 to bit 7 clears it, and writing 0 to bit 7 leaves it unchanged.
- R6: With free-run at 0, the step that sets the flag loads the counter with zero. With free-run at 1, the counter steps on and wraps from 0xFFFF to 0.
- R7: `irq` is high exactly when the interrupt enable and the match flag are both 1.
- R8: `trig` rises on the matching step and falls on the next step. With a compare value of 0, it stays high until the timer is stopped.
- R9: While the run bit is 0, the counter, the flag and `trig` are held at zero.
- R10: While the run bit is 1, writes do not change the mode, free-run, polarity, input select or prescaler fields. A control write whose bit 0 is 1 never changes bits 5:1.
- R11: The compare register (offset 0x8) keeps bits 15:0 and reads zero above them. A write to it takes effect only while the timer is stopped or the match flag is set.
- R12: Reading offset 0xC returns the live counter value. Writes to that offset are ignored.
- R13: The prescaler word (offset 0x4) holds the divide code at bits 3:0, bypass at bit 4 and clock select at bits 6:5. Bits 31:7 read zero. These fields drive `pre_div`, `pre_bypass` and `pre_clk_sel`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, single cycle |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| count_en | input | 1 | Count strobe from the prescaler stage (time mode) |
| pulse_in | input | 4 | External pulse inputs (pulse mode) |
| pre_clk_sel | output | 2 | Prescaler clock select |
| pre_bypass | output | 1 | Prescaler bypass |
| pre_div | output | 4 | Prescaler divide code |
| irq | output | 1 | Interrupt request |
| trig | output | 1 | Hardware trigger |

## Verification
A wrong counter value shows up in the counter read at once. It also shows up in `trig` and `irq` at the next step that should or should not match, so the error is visible within one step of the strobe. A stale or lost match flag appears on `irq` in the cycle after the faulty edge, and a dropped trigger appears on `trig` in the same cycle. The bench mirrors the whole state in a behavioural model and compares `irq`, `trig` and the prescaler outputs on every clock, so a fault is caught in the cycle it reaches a port.

// File: rtl/cmt_pkg.sv
// Shared definitions for the compare-match timer core: register slots
// and the fixed bit positions of the control word.
// Assumes a 32-bit register port with byte offsets 0x0..0xC.
package cmt_pkg;
    // Register slot, decoded from byte-address bits 3:2
    typedef enum logic [1:0] {
        SLOT_CTRL = 2'd0,
        SLOT_PRE  = 2'd1,
        SLOT_CMP  = 2'd2,
        SLOT_CNT  = 2'd3
    } slot_e;

    // Control word bit positions
    localparam int CTL_RUN    = 0;
    localparam int CTL_MODE   = 1;
    localparam int CTL_FREE   = 2;
    localparam int CTL_POL    = 3;
    localparam int CTL_SEL_LO = 4;
    localparam int CTL_IE     = 6;
    localparam int CTL_FLAG   = 7;

    // Prescaler word: divide code at the bottom, then bypass, then clock select
    localparam int PRE_DIV_LO = 0;
endpackage

// File: rtl/cmt_regs.sv
// Register bank of the compare-match timer.
// It holds the control fields, the prescaler fields and the compare value,
// and it builds the read data. The counter value and the match flag are
// read from the counter unit.
// Assumes: SEL_W <= 2, so the input select fits below the interrupt-enable bit.
module cmt_regs
    import cmt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4,
    parameter int CNT_W  = 16,
    parameter int DIV_W  = 4,
    parameter int CSEL_W = 2,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic              flag,
    output logic              run,
    output logic              mode,
    output logic              free,
    output logic              pol,
    output logic [SEL_W-1:0]  sel,
    output logic              ie,
    output logic [CNT_W-1:0]  cmp,
    output logic [DIV_W-1:0]  div,
    output logic              bypass,
    output logic [CSEL_W-1:0] csel,
    output logic              flag_clr,
    output logic [DATA_W-1:0] rdata
);
    localparam int PRE_BYP_POS = PRE_DIV_LO + DIV_W;
    localparam int PRE_CS_LO   = PRE_BYP_POS + 1;

    slot_e slot;
    logic  wr_ctrl, wr_pre, wr_cmp;
    logic  unused_addr_bits;

    assign slot             = slot_e'(addr[3:2]);
    assign unused_addr_bits = ^{addr[1:0], wdata};
    assign wr_ctrl          = wr && (slot == SLOT_CTRL);
    assign wr_pre           = wr && (slot == SLOT_PRE);
    assign wr_cmp           = wr && (slot == SLOT_CMP);

    // Request a flag clear when a one is written to the flag bit
    assign flag_clr = wr_ctrl && wdata[CTL_FLAG];

    // Run and interrupt-enable bits: writable at any time
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
            ie  <= 1'b0;
        end else if (wr_ctrl) begin
            run <= wdata[CTL_RUN];
            ie  <= wdata[CTL_IE];
        end
    end

    // Operating fields: written only while stopped and not being started
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= 1'b0;
            free <= 1'b0;
            pol  <= 1'b0;
            sel  <= '0;
        end else if (wr_ctrl && !run && !wdata[CTL_RUN]) begin
            mode <= wdata[CTL_MODE];
            free <= wdata[CTL_FREE];
            pol  <= wdata[CTL_POL];
            sel  <= wdata[CTL_SEL_LO +: SEL_W];
        end
    end

    // Prescaler fields: written only while stopped
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div    <= '0;
            bypass <= 1'b0;
            csel   <= '0;
        end else if (wr_pre && !run) begin
            div    <= wdata[PRE_DIV_LO +: DIV_W];
            bypass <= wdata[PRE_BYP_POS];
            csel   <= wdata[PRE_CS_LO +: CSEL_W];
        end
    end

    // Compare value: written while stopped or while the flag is set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp <= '0;
        end else if (wr_cmp && (!run || flag)) begin
            cmp <= wdata[CNT_W-1:0];
        end
    end

    // Read multiplexer; unimplemented bits read zero
    always_comb begin
        rdata = '0;
        unique case (slot)
            SLOT_CTRL: begin
                rdata[CTL_RUN]               = run;
                rdata[CTL_MODE]              = mode;
                rdata[CTL_FREE]              = free;
                rdata[CTL_POL]               = pol;
                rdata[CTL_SEL_LO +: SEL_W]   = sel;
                rdata[CTL_IE]                = ie;
                rdata[CTL_FLAG]              = flag;
            end
            SLOT_PRE: begin
                rdata[PRE_DIV_LO +: DIV_W]   = div;
                rdata[PRE_BYP_POS]           = bypass;
                rdata[PRE_CS_LO +: CSEL_W]   = csel;
            end
            SLOT_CMP: rdata[CNT_W-1:0] = cmp;
            SLOT_CNT: rdata[CNT_W-1:0] = cnt_val;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/cmt_edge.sv
// Pulse-input front end of the timer.
// It corrects the polarity of every input, picks the selected one and
// reports a one-cycle strobe on each active edge.
// Assumes the inputs are already synchronous to clk.
module cmt_edge #(
    parameter int N_PULSE = 4,
    parameter int SEL_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_PULSE-1:0] pulse_in,
    input  logic [SEL_W-1:0]   sel,
    input  logic               pol,
    output logic               edge_stb
);
    logic [N_PULSE-1:0] norm;
    logic               level;
    logic               level_q;

    // Polarity correction: the active level becomes 1 on every input
    for (genvar i = 0; i < N_PULSE; i++) begin : g_norm
        assign norm[i] = pulse_in[i] ^ pol;
    end

    assign level = norm[sel];

    // Track the last level so that a 0-to-1 step can be seen
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level;
    end

    assign edge_stb = level && !level_q;
endmodule

// File: rtl/cmt_count.sv
// Counter, match flag and trigger of the timer.
// A step comes from count_en in time mode or from the edge strobe in pulse
// mode. A step taken at the compare value sets the flag and raises the
// trigger. Stopping the timer clears the whole state.
module cmt_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             mode,
    input  logic             free,
    input  logic [CNT_W-1:0] cmp,
    input  logic             count_en,
    input  logic             edge_stb,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cnt,
    output logic             flag,
    output logic             trig,
    output logic             tick
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic match;
    logic cmp_zero;

    assign tick     = run && (mode ? edge_stb : count_en);
    assign match    = (cnt == cmp);
    assign cmp_zero = (cmp == '0);

    // Counter: step, rewind on match unless free-running, clear when stopped
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (tick) begin
            if (match && !free) cnt <= '0;
            else                cnt <= cnt + ONE;
        end
    end

    // Trigger: high from the matching step until the next step, or held if compare is zero
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            trig <= 1'b0;
        end else if (tick) begin
            trig <= match || (trig && cmp_zero);
        end
    end

    // Sticky match flag: a set wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            flag <= 1'b0;
        end else if (tick && match) begin
            flag <= 1'b1;
        end else if (flag_clr) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/cmt_core.sv
// Top of the compare-match timer core.
// It ties together the register bank, the pulse edge front end and the
// counter unit, and it drives the interrupt and the prescaler settings.
// Assumes the word-wide register port completes every access in one cycle.
module cmt_core #(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 4,
    parameter int CNT_W   = 16,
    parameter int DIV_W   = 4,
    parameter int CSEL_W  = 2,
    parameter int N_PULSE = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic               count_en,
    input  logic [N_PULSE-1:0] pulse_in,
    output logic [CSEL_W-1:0]  pre_clk_sel,
    output logic               pre_bypass,
    output logic [DIV_W-1:0]   pre_div,
    output logic               irq,
    output logic               trig
);
    localparam int SEL_W = (N_PULSE > 1) ? $clog2(N_PULSE) : 1;

    logic             run_q, mode_q, free_q, pol_q, ie_q;
    logic [SEL_W-1:0] sel_q;
    logic [CNT_W-1:0] cmp_q, cnt_q;
    logic             flag_q, flag_clr_w, edge_w, tick_w;

    cmt_regs #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
        .DIV_W(DIV_W), .CSEL_W(CSEL_W), .SEL_W(SEL_W)
    ) regs_i (
        .clk(clk), .rst_n(rst_n),
        .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .cnt_val(cnt_q), .flag(flag_q),
        .run(run_q), .mode(mode_q), .free(free_q), .pol(pol_q),
        .sel(sel_q), .ie(ie_q), .cmp(cmp_q),
        .div(pre_div), .bypass(pre_bypass), .csel(pre_clk_sel),
        .flag_clr(flag_clr_w), .rdata(bus_rdata)
    );

    cmt_edge #(.N_PULSE(N_PULSE), .SEL_W(SEL_W)) edge_i (
        .clk(clk), .rst_n(rst_n),
        .pulse_in(pulse_in), .sel(sel_q), .pol(pol_q),
        .edge_stb(edge_w)
    );

    cmt_count #(.CNT_W(CNT_W)) count_i (
        .clk(clk), .rst_n(rst_n),
        .run(run_q), .mode(mode_q), .free(free_q), .cmp(cmp_q),
        .count_en(count_en), .edge_stb(edge_w), .flag_clr(flag_clr_w),
        .cnt(cnt_q), .flag(flag_q), .trig(trig), .tick(tick_w)
    );

    // Interrupt request: the flag gated by the interrupt enable
    assign irq = flag_q && ie_q;
endmodule

// File: rtl/cmt_core_chk.sv
// Property checker for cmt_core, attached through bind.
// It watches the run bit, the counter, the flag, the trigger and the compare value.
module cmt_core_chk #(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic              free,
    input logic              tick,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  cmp,
    input logic              flag,
    input logic              trig,
    input logic              irq,
    input logic              wr,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_inc_q;
    logic             w1c;

    // Counter value plus one, registered for the step check
    always_ff @(posedge clk) cnt_inc_q <= cnt + ONE;

    assign w1c = wr && (addr[3:2] == 2'd0) && wdata[7];

    // R9
    stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0 && !flag && !trig));

    // R6
    match_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(flag) && !free) |-> (cnt == '0));

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> (cnt == $past(cnt)));

    // R3
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && cnt != cmp) |=> (cnt == cnt_inc_q));

    // R8
    trig_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && trig && !tick) |=> trig);

    // R5
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && flag && !w1c) |=> flag);

    // R11
    cmp_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !flag) |=> $stable(cmp));

    // R7
    irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag);
endmodule

bind cmt_core cmt_core_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .run(run_q), .free(free_q), .tick(tick_w),
    .cnt(cnt_q), .cmp(cmp_q), .flag(flag_q), .trig(trig), .irq(irq),
    .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata)
);

// File: tb/cmt_core_tb_top.sv
// Bench for cmt_core: a behavioural model follows every clock, and the
// outputs and register reads are compared against it.
module cmt_core_tb_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        count_en = 1'b0;
    logic [3:0]  pulse_in = '0;
    logic [1:0]  pre_clk_sel;
    logic        pre_bypass;
    logic [3:0]  pre_div;
    logic        irq, trig;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    cmt_core dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .count_en(count_en),
        .pulse_in(pulse_in), .pre_clk_sel(pre_clk_sel), .pre_bypass(pre_bypass),
        .pre_div(pre_div), .irq(irq), .trig(trig)
    );

    // ---------------- behavioural model ----------------
    bit        m_run, m_mode, m_free, m_pol, m_ie, m_flag, m_trig, m_prev;
    bit [1:0]  m_sel, m_csel;
    bit        m_byp;
    bit [3:0]  m_div;
    int        m_cmp, m_cnt;

    always @(posedge clk) begin
        bit lvl, stepped, hit, clr;
        if (!rst_n) begin
            m_run = 0; m_mode = 0; m_free = 0; m_pol = 0; m_ie = 0;
            m_flag = 0; m_trig = 0; m_prev = 0; m_sel = 0; m_csel = 0;
            m_byp = 0; m_div = 0; m_cmp = 0; m_cnt = 0;
        end else begin
            lvl = pulse_in[m_sel] ^ m_pol;
            stepped = m_run && (m_mode ? (lvl && !m_prev) : count_en);
            hit = stepped && (m_cnt == m_cmp);
            clr = bus_wr && bus_addr[3:2] == 0 && bus_wdata[7];
            m_prev = lvl;
            if (!m_run) begin
                m_cnt = 0; m_flag = 0; m_trig = 0;
            end else begin
                if (stepped) begin
                    m_trig = hit || (m_trig && m_cmp == 0);
                    if (hit && !m_free) m_cnt = 0;
                    else m_cnt = (m_cnt + 1) % 65536;
                end
                if (hit) m_flag = 1;
                else if (clr) m_flag = 0;
            end
            if (bus_wr) begin
                case (bus_addr[3:2])
                    2'd0: begin
                        if (!m_run && !bus_wdata[0]) begin
                            m_mode = bus_wdata[1]; m_free = bus_wdata[2];
                            m_pol = bus_wdata[3]; m_sel = bus_wdata[5:4];
                        end
                        m_run = bus_wdata[0]; m_ie = bus_wdata[6];
                    end
                    2'd1: if (!m_run) begin
                        m_div = bus_wdata[3:0]; m_byp = bus_wdata[4]; m_csel = bus_wdata[6:5];
                    end
                    2'd2: if (!m_run || m_flag) m_cmp = bus_wdata[15:0];
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [31:0] m_read(input logic [3:0] a);
        case (a[3:2])
            2'd0: return {24'd0, m_flag, m_ie, m_sel, m_pol, m_free, m_mode, m_run};
            2'd1: return {25'd0, m_csel, m_byp, m_div};
            2'd2: return 32'(m_cmp);
            default: return 32'(m_cnt);
        endcase
    endfunction

    // ---------------- checking helpers ----------------
    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Every clock: trigger, interrupt and prescaler outputs against the model (R7, R8, R13)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(trig === m_trig, "R8 trig", 32'(trig), 32'(m_trig));
            check(irq === (m_ie && m_flag), "R7 irq", 32'(irq), 32'(m_ie && m_flag));
            check({pre_clk_sel, pre_bypass, pre_div} === {m_csel, m_byp, m_div},
                  "R13 prescaler outputs", 32'({pre_clk_sel, pre_bypass, pre_div}),
                  32'({m_csel, m_byp, m_div}));
        end
    end

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input string req);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(bus_rdata === m_read(a), req, bus_rdata, m_read(a));
    endtask

    task automatic rd_const(input logic [3:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(bus_rdata === exp, req, bus_rdata, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic toggle(input int idx, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            pulse_in[idx] = ~pulse_in[idx];
            pulse_in[0] = ~pulse_in[0];
            @(negedge clk);
        end
    endtask

    // ---------------- stimulus ----------------
    initial begin
        idle(4);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        rd_const(4'h0, 32'h0, "R1 ctrl after reset");
        rd_const(4'h4, 32'h0, "R1 prescaler after reset");
        rd_const(4'h8, 32'h0, "R1 compare after reset");
        rd_const(4'hC, 32'h0, "R1 counter after reset");
        check(irq === 1'b0 && trig === 1'b0, "R1 outputs low", 32'({irq, trig}), 32'h0);

        // R13 prescaler layout
        wr_reg(4'h4, 32'hFFFF_FF5B);
        rd_const(4'h4, 32'h0000_005B, "R13 prescaler readback");
        check(pre_div === 4'hB && pre_bypass === 1'b1 && pre_clk_sel === 2'd2,
              "R13 prescaler ports", 32'({pre_clk_sel, pre_bypass, pre_div}), 32'h5B);

        // R2 control layout, reserved bits read zero
        wr_reg(4'h0, 32'hFFFF_FF7E);
        rd_const(4'h0, 32'h0000_007E, "R2 ctrl readback");
        wr_reg(4'h0, 32'h0);

        // R3 time mode counting with a gapped strobe
        wr_reg(4'h8, 32'd4);
        wr_reg(4'h0, 32'h40);
        wr_reg(4'h0, 32'h41);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk) count_en = (i % 3 != 0);
        end
        @(negedge clk) count_en = 1'b0;
        rd_chk(4'hC, "R3 counter after strobes");
        rd_chk(4'h0, "R5 flag after match");

        // R12 counter writes ignored
        wr_reg(4'hC, 32'h1234);
        rd_chk(4'hC, "R12 counter write ignored");

        // R5 write 0 keeps flag, write 1 clears it
        wr_reg(4'h0, 32'h41);
        rd_const(4'h0, 32'h0000_00C1, "R5 flag kept on zero write");
        wr_reg(4'h0, 32'hC1);
        rd_const(4'h0, 32'h0000_0041, "R5 flag cleared by one write");

        // R10 fields locked while running
        wr_reg(4'h0, 32'h7F);
        rd_const(4'h0, 32'h0000_0041, "R10 ctrl fields locked");
        wr_reg(4'h4, 32'h0);
        rd_const(4'h4, 32'h0000_005B, "R10 prescaler locked");

        // R11 compare locked while running without flag, open once flag set
        wr_reg(4'h8, 32'd9);
        rd_const(4'h8, 32'd4, "R11 compare write blocked");
        @(negedge clk) count_en = 1'b1;
        idle(6);
        @(negedge clk) count_en = 1'b0;
        rd_chk(4'h0, "R5 flag set again");
        wr_reg(4'h8, 32'd6);
        rd_const(4'h8, 32'd6, "R11 compare write with flag set");

        // R9 stopping clears everything
        wr_reg(4'h0, 32'h0);
        rd_const(4'hC, 32'h0, "R9 counter cleared");
        rd_const(4'h0, 32'h0, "R9 flag cleared");
        check(trig === 1'b0, "R9 trig low", 32'(trig), 32'h0);

        // R11 upper compare bits not kept
        wr_reg(4'h8, 32'hABCD_0009);
        rd_const(4'h8, 32'h0000_0009, "R11 compare upper half zero");

        // R8 compare of zero holds the trigger
        wr_reg(4'h8, 32'd0);
        wr_reg(4'h0, 32'h01);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk) count_en = 1'b1;
            @(negedge clk) count_en = 1'b0;
            idle(3);
        end
        check(trig === 1'b1, "R8 trig held with zero compare", 32'(trig), 32'h1);
        check(irq === 1'b0, "R7 irq masked", 32'(irq), 32'h0);
        wr_reg(4'h0, 32'h0);
        idle(1);
        check(trig === 1'b0, "R8 trig released on stop", 32'(trig), 32'h0);

        // R4 pulse mode, rising edges on input 2, strobe ignored
        wr_reg(4'h8, 32'd3);
        wr_reg(4'h0, 32'h22);
        wr_reg(4'h0, 32'h63);
        @(negedge clk) count_en = 1'b1;
        toggle(2, 10);
        @(negedge clk) count_en = 1'b0;
        rd_chk(4'hC, "R4 rising-edge count");
        rd_chk(4'h0, "R4 flag in pulse mode");

        // R4 pulse mode, falling edges on input 1
        wr_reg(4'h0, 32'h0);
        wr_reg(4'h0, 32'h1A);
        wr_reg(4'h0, 32'h1B);
        toggle(1, 7);
        rd_chk(4'hC, "R4 falling-edge count");

        // R6 free-running wrap past 0xFFFF
        wr_reg(4'h0, 32'h0);
        wr_reg(4'h8, 32'd2);
        wr_reg(4'h0, 32'h04);
        wr_reg(4'h0, 32'h45);
        @(negedge clk) count_en = 1'b1;
        idle(65545);
        @(negedge clk) count_en = 1'b0;
        rd_chk(4'hC, "R6 counter after wrap");
        rd_chk(4'h0, "R6 flag with free run");
        check(m_cnt < 16, "R6 model wrapped", 32'(m_cnt), 32'd15);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog
    initial begin
        #(CLK_P * 190000);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=0x0 expected=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule